// File: doc/BRIEF.md
# Phase Accumulator Oscillator Core

This block is the digital core of a numerically controlled oscillator. A 32-bit phase register advances on every system clock by the active tuning word, so the output frequency is `tuning word × fclk / 2^32`. A 5-bit phase adjustment is added to the top of the phase, which gives steps of 360/32 = 11.25 degrees. The top 12 bits of the adjusted phase address a quarter-wave sine table. The table produces a 10-bit offset-binary sample, and the most significant phase bit is brought out as a square-wave bit.

A control interface presents a new tuning word and phase adjustment together with a one-cycle load pulse. The new phase adjustment reaches the output a fixed 13 clocks after the load edge, and the new frequency 18 clocks after it. Loads may be issued on consecutive cycles, and each one is delivered at its own latency. Reset brings the output to 0 Hz at 0 degrees and discards any update still in flight. Power-down freezes the phase and parks the output at mid-scale.

Top module: `nco_core`

## Requirements
- R1: After a clock edge with `rst` high, `sample` is 512 (the mid-scale code, meaning zero) and `square` is 0. With no load since reset, the output stays at 512 / 0.
- R2: While running, the phase advances by `tuneWord` on every clock, modulo 2^32. Bits 31..20 of the phase (plus the adjustment) form the 12-bit table address A.
- R3: `sample` equals 512 + round(511·sin(2π(A+0.5)/4096)), within ±1 code. It therefore lies in 1..1023, and it never reads 0.
- R4: `square` equals bit 11 of the adjusted address A, the same A as the `sample` shown in that cycle. When `square` is 1, `sample` ≤ 512; when it is 0, `sample` ≥ 512.
- R5: A phase adjustment value k adds k·128 to A, modulo 4096, which is a step of 11.25 degrees per unit.
- R6: Count the edge at which `loadStb` is sampled high as edge 0. The new tuning word sets the increment applied for the output shown after edge 18. The output after edge 17 still follows the old word.
- R7: With the same edge numbering, the new phase adjustment first appears in the output after edge 13. The output after edge 12 is unaffected.
- R8: `tuneWord` and `phaseOfs` are ignored on edges where `loadStb` is low.
- R9: On every edge with `pwrDown` high, the output is 512 / 0 and the phase does not advance. After release, the sample sequence continues from the exact point where it paused.
- R10: Loads on consecutive edges are each delivered at their own latencies from R6 and R7.
- R11: A reset discards every load still in flight. No update issued before a reset ever takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwrDown | input | 1 | Freeze phase and park the output at mid-scale |
| loadStb | input | 1 | One-cycle pulse that captures `tuneWord` and `phaseOfs` |
| tuneWord | input | 32 | Phase increment per clock |
| phaseOfs | input | 5 | Phase adjustment in 11.25-degree steps |
| sample | output | 10 | Offset-binary sine sample |
| square | output | 1 | Most significant bit of the adjusted phase |

## Verification
The bench loads a tuning word and a phase adjustment on the same edge and looks at the outputs after edges 12, 13, 17 and 18. A design with one pipeline stage too many or too few, or with the two paths swapped, puts a large code step in the wrong cycle. It also loads on three consecutive edges and resets while a load is in flight. A design that captures only the latest load, or lets a stale update survive reset, then drifts away from 512 or from the expected phase. Power-down is held for several cycles and released. A design that keeps the phase advancing, or that drops or repeats a sample on resume, moves out of step with the reference sequence. The bench also runs increments large enough to wrap the phase, including a negative step, and phase adjustments near 31. These catch a broken quadrant mirror, a broken sign or a broken modulo.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clr;       // synchronous clear of all state
    logic run;       // advance phase, drive live samples
    logic tuneLoad;  // delayed tuning word is due now
    logic ofsLoad;   // delayed phase adjustment is due now
  } nco_ctrl_t;
endpackage

// File: rtl/nco_delay_line.sv
module nco_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int FREQ_LAT  = 18,  // must exceed PHASE_LAT
  parameter int PHASE_LAT = 13
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pwrDown,
  input  logic      loadStb,
  output nco_ctrl_t ctrl
);
  // Three register stages sit after the active-word registers on the frequency
  // path (phase, sum, sample) and two on the phase path (sum, sample).
  localparam int CHAIN   = FREQ_LAT - 3;
  localparam int TUNE_TAP = FREQ_LAT - 4;
  localparam int OFS_TAP  = PHASE_LAT - 3;

  logic [CHAIN-1:0] pendFlags;

  always_ff @(posedge clk) begin
    if (rst) pendFlags <= '0;
    else     pendFlags <= {pendFlags[CHAIN-2:0], loadStb};
  end

  always_comb begin
    ctrl.clr      = rst;
    ctrl.run      = ~pwrDown;
    ctrl.tuneLoad = pendFlags[TUNE_TAP];
    ctrl.ofsLoad  = pendFlags[OFS_TAP];
  end
endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom #(
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  code
);
  localparam int QW    = ADDR_W - 2;
  localparam int QD    = 1 << QW;
  localparam int MAG_W = OUT_W - 1;
  localparam longint AMP    = (longint'(1) << (OUT_W - 1)) - 1;
  localparam longint PI_Q30 = 64'sd3373259426;
  localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(1) << (OUT_W - 1);

  // Magnitude at the centre of quarter-wave bin idx, Taylor series in Q30
  function automatic logic [MAG_W-1:0] quarterMag(input int idx);
    longint x, term, sum, mag;
    x    = (PI_Q30 * longint'(2 * idx + 1)) / longint'(4 * QD);
    term = x;
    sum  = x;
    for (int k = 1; k <= 6; k++) begin
      term = -((((term * x) >>> 30) * x) >>> 30) / longint'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    mag = (sum * AMP + (longint'(1) <<< 29)) >>> 30;
    return MAG_W'(mag);
  endfunction

  logic [MAG_W-1:0] magTab [QD];
  for (genvar i = 0; i < QD; i++) begin : g_tab
    assign magTab[i] = quarterMag(i);
  end

  logic [1:0]    quad;
  logic [QW-1:0] idx, tabIdx;
  logic [OUT_W-1:0] magExt;

  always_comb begin
    quad   = addr[ADDR_W-1 -: 2];
    idx    = addr[QW-1:0];
    tabIdx = quad[0] ? ~idx : idx;        // mirror in quadrants 1 and 3
    magExt = {1'b0, magTab[tabIdx]};
    code   = quad[1] ? MID_CODE - magExt  // lower half-cycle below mid-scale
                     : MID_CODE + magExt;
  end
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int OFS_W     = 5,
  parameter int ADDR_W    = 12,
  parameter int OUT_W     = 10,
  parameter int FREQ_LAT  = 18,
  parameter int PHASE_LAT = 13
) (
  input  logic             clk,
  input  nco_ctrl_t        ctrl,
  input  logic [ACC_W-1:0] tuneWord,
  input  logic [OFS_W-1:0] phaseOfs,
  output logic [OUT_W-1:0] sample,
  output logic             square
);
  localparam int TUNE_DEPTH = FREQ_LAT - 3;
  localparam int OFS_DEPTH  = PHASE_LAT - 2;
  localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(1) << (OUT_W - 1);

  logic [ACC_W-1:0]  tuneDly, activeTune, accQ;
  logic [OFS_W-1:0]  ofsDly, activeOfs;
  logic [ADDR_W-1:0] sumQ;
  logic [OUT_W-1:0]  romCode, sampleQ;
  logic              squareQ;

  nco_delay_line #(.W(ACC_W), .DEPTH(TUNE_DEPTH)) tune_dly_i (
    .clk(clk), .rst(ctrl.clr), .din(tuneWord), .dout(tuneDly)
  );

  nco_delay_line #(.W(OFS_W), .DEPTH(OFS_DEPTH)) ofs_dly_i (
    .clk(clk), .rst(ctrl.clr), .din(phaseOfs), .dout(ofsDly)
  );

  always_ff @(posedge clk) begin
    if (ctrl.clr) begin
      activeTune <= '0;
      activeOfs  <= '0;
    end else begin
      if (ctrl.tuneLoad) activeTune <= tuneDly;
      if (ctrl.ofsLoad)  activeOfs  <= ofsDly;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.clr) begin
      accQ <= '0;
      sumQ <= '0;
    end else if (ctrl.run) begin
      accQ <= accQ + activeTune;
      sumQ <= accQ[ACC_W-1 -: ADDR_W] + {activeOfs, {(ADDR_W-OFS_W){1'b0}}};
    end
  end

  nco_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) rom_i (
    .addr(sumQ), .code(romCode)
  );

  always_ff @(posedge clk) begin
    if (ctrl.clr || !ctrl.run) begin
      sampleQ <= MID_CODE;
      squareQ <= 1'b0;
    end else begin
      sampleQ <= romCode;
      squareQ <= sumQ[ADDR_W-1];
    end
  end

  assign sample = sampleQ;
  assign square = squareQ;
endmodule

// File: rtl/nco_core.sv
module nco_core
  import nco_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int OFS_W     = 5,
  parameter int ADDR_W    = 12,
  parameter int OUT_W     = 10,
  parameter int FREQ_LAT  = 18,
  parameter int PHASE_LAT = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwrDown,
  input  logic             loadStb,
  input  logic [ACC_W-1:0] tuneWord,
  input  logic [OFS_W-1:0] phaseOfs,
  output logic [OUT_W-1:0] sample,
  output logic             square
);
  nco_ctrl_t ctrl;

  nco_ctrl #(.FREQ_LAT(FREQ_LAT), .PHASE_LAT(PHASE_LAT)) ctrl_i (
    .clk(clk), .rst(rst), .pwrDown(pwrDown), .loadStb(loadStb), .ctrl(ctrl)
  );

  nco_datapath #(
    .ACC_W(ACC_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W),
    .FREQ_LAT(FREQ_LAT), .PHASE_LAT(PHASE_LAT)
  ) dp_i (
    .clk(clk), .ctrl(ctrl), .tuneWord(tuneWord), .phaseOfs(phaseOfs),
    .sample(sample), .square(square)
  );
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
  parameter int OUT_W     = 10,
  parameter int PHASE_LAT = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             pwrDown,
  input logic             loadStb,
  input logic [OUT_W-1:0] sample,
  input logic             square
);
  localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(1) << (OUT_W - 1);
  localparam int AGE_W = $clog2(PHASE_LAT + 1);

  // Edges since the first load after reset
  logic             quietQ;
  logic [AGE_W-1:0] ageQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      quietQ <= 1'b1;
      ageQ   <= '0;
    end else if (quietQ && loadStb) begin
      quietQ <= 1'b0;
      ageQ   <= '0;
    end else if (!quietQ && ageQ < AGE_W'(PHASE_LAT)) begin
      ageQ <= ageQ + 1'b1;
    end
  end

  AST_RESET_MID: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sample == MID_CODE && !square));  // R1

  AST_PARK_MID: assert property (@(posedge clk) disable iff (rst)
    pwrDown |=> (sample == MID_CODE && !square));  // R9

  AST_SQUARE_HALF: assert property (@(posedge clk) disable iff (rst)
    square |-> (sample <= MID_CODE));  // R4

  AST_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    !square |-> (sample >= MID_CODE));  // R4

  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    sample != '0);  // R3

  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (quietQ || ageQ <= AGE_W'(PHASE_LAT - 1)) |-> (sample == MID_CODE));  // R7
endmodule

bind nco_core nco_core_chk #(.OUT_W(OUT_W), .PHASE_LAT(PHASE_LAT)) chk_i (.*);

// File: tb/nco_core_tb.sv
`timescale 1ns/1ps
module nco_core_tb_top;
  localparam int FL = 18;
  localparam int PL = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwrDown = 1'b0;
  logic        loadStb = 1'b0;
  logic [31:0] tuneWord = '0;
  logic [4:0]  phaseOfs = '0;
  logic [9:0]  sample;
  logic        square;

  always #2.5 clk = ~clk;

  nco_core dut_i (
    .clk(clk), .rst(rst), .pwrDown(pwrDown), .loadStb(loadStb),
    .tuneWord(tuneWord), .phaseOfs(phaseOfs), .sample(sample), .square(square)
  );

  typedef struct {
    int    code;
    logic  sq;
    bit    exact;
    string tag;
  } exp_t;

  typedef struct {
    int          due;
    logic [31:0] val;
  } evt_t;

  exp_t  sbQ[$];
  evt_t  tuneQ[$];
  evt_t  ofsQ[$];
  int    errors = 0;
  int    checks = 0;
  bit    finished = 0;
  string curReq = "R1";

  // Reference model state
  logic [31:0] vAcc = '0;
  logic [31:0] curTune = '0;
  logic [4:0]  curOfs = '0;
  int          cyc = 0;

  function automatic int expCode(input logic [11:0] a);
    real ang, v;
    int  r;
    ang = 3.141592653589793 * (2.0 * real'(a) + 1.0) / 4096.0;
    v   = 511.0 * $sin(ang);
    if (v >= 0.0) r = int'($floor(v + 0.5));
    else          r = -int'($floor(-v + 0.5));
    return 512 + r;
  endfunction

  task automatic pushExp(input int code, input logic sq, input bit exact);
    exp_t e;
    e.code = code; e.sq = sq; e.exact = exact; e.tag = curReq;
    sbQ.push_back(e);
  endtask

  // Driver: one clock of stimulus, then the expected result for that edge
  task automatic step(input logic r, input logic ld, input logic pd,
                      input logic [31:0] tw, input logic [4:0] po);
    evt_t        ev;
    logic [11:0] a;
    rst = r; loadStb = ld; pwrDown = pd; tuneWord = tw; phaseOfs = po;
    @(posedge clk);
    if (r) begin
      vAcc = '0; curTune = '0; curOfs = '0; cyc = 0;
      tuneQ.delete(); ofsQ.delete();
      pushExp(512, 1'b0, 1'b1);
    end else begin
      cyc++;
      if (ld) begin
        ev.due = cyc + FL; ev.val = tw;          tuneQ.push_back(ev);
        ev.due = cyc + PL; ev.val = {27'd0, po}; ofsQ.push_back(ev);
      end
      while (tuneQ.size() > 0 && tuneQ[0].due <= cyc) curTune = tuneQ.pop_front().val;
      while (ofsQ.size() > 0 && ofsQ[0].due <= cyc)   curOfs  = ofsQ.pop_front().val[4:0];
      if (pd) begin
        pushExp(512, 1'b0, 1'b1);
      end else begin
        vAcc = vAcc + curTune;
        a = vAcc[31:20] + {curOfs, 7'd0};
        pushExp(expCode(a), a[11], 1'b0);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 32'h0, 5'd0);
  endtask

  task automatic load(input logic [31:0] tw, input logic [4:0] po);
    step(1'b0, 1'b1, 1'b0, tw, po);
  endtask

  // Monitor: compare each design result against the scoreboard
  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      exp_t e;
      int   diff;
      bit   bad;
      e = sbQ.pop_front();
      checks++;
      diff = int'(sample) - e.code;
      bad  = $isunknown({sample, square}) || (square !== e.sq) ||
             (e.exact ? (diff != 0) : (diff > 1 || diff < -1));
      if (bad) begin
        errors++;
        $display("FAIL %s: sample=%0d square=%0b expected sample=%0d square=%0b",
                 e.tag, sample, square, e.code, e.sq);
      end
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state and quiet hold
    curReq = "R1";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 5'd0);
    idle(10);

    // R8: data lines toggle without a load pulse
    curReq = "R8";
    for (int i = 0; i < 20; i++)
      step(1'b0, 1'b0, 1'b0, 32'hA5A5_0000 ^ (i * 32'h0137_1111), 5'(i + 3));

    // R7 then R6: joint load, phase lands at 13, frequency at 18
    curReq = "R7";
    load(32'h0400_0000, 5'd8);
    idle(15);
    curReq = "R6";
    idle(25);

    // R3 / R2: sweep all quadrants, then a wrapping negative step
    curReq = "R3";
    load(32'h1234_5678, 5'd0);
    idle(300);
    curReq = "R2";
    load(32'hFFF0_0000, 5'd0);
    idle(100);

    // R5: phase adjustment steps with the phase frozen
    curReq = "R5";
    load(32'h0, 5'd1);   idle(20);
    load(32'h0, 5'd16);  idle(20);
    load(32'h0, 5'd31);  idle(20);

    // R4: square wave tracks the adjusted top bit
    curReq = "R4";
    load(32'h0100_0000, 5'd5);
    idle(100);

    // R9: park and resume
    curReq = "R9";
    load(32'h00C0_0000, 5'd0);
    idle(25);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 5'd9);
    idle(30);

    // R10: loads on consecutive edges
    curReq = "R10";
    load(32'h0200_0000, 5'd3);
    load(32'h0300_0000, 5'd17);
    load(32'h0080_0000, 5'd30);
    idle(40);

    // R11: reset drops an in-flight update
    curReq = "R11";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 5'd0);
    load(32'h0800_0000, 5'd12);
    idle(5);
    for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, 32'h0, 5'd0);
    idle(30);

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule